// File: doc/BRIEF.md
# Two-Stage System Watchdog

This block is a system watchdog with two escalation stages. It sits on a simple 32-bit memory-mapped bus through two independent register windows. The first is a refresh window, where any write to its refresh word restarts the timeout. The second is a control window, which holds the enable bit, the status bits, a 48-bit timeout offset and a 64-bit compare value. The watchdog does not count by itself. It compares the compare value against a free-running 64-bit system count that comes in on `count_i`.

While the watchdog is enabled, every refresh loads the compare value with the current count plus the offset. When the count reaches the compare value for the first time, the block sets the first-stage status, raises `irq_o` and rearms itself one offset later. If the count reaches the compare value again with no refresh in between, the block sets the second-stage status and raises `rst_req_o`. Something outside the block acts on that request.

Both windows answer only naturally aligned 32-bit accesses. An address the decoder does not know reads as zero and ignores writes. Read data is combinational and valid in the same cycle as the select.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the status word, both offset words and both compare words read as zero. The identity word (control 0xFCC, refresh 0xFCC) reads ID_VALUE. `irq_o` and `rst_req_o` are low.
- R2: A write of any data to the refresh word (refresh window 0x000) clears both stage bits and, if the watchdog is enabled, loads compare = count + offset. A read of refresh 0x000 returns zero and changes nothing.
- R3: Offset-low (control 0x008) stores 32 bits. Offset-high (control 0x00C) stores only write bits [15:0] and reads back zero-extended. Together they form a 48-bit offset {high, low}.
- R4: A write to the status word (control 0x000) keeps only data bit 0 as the enable. It clears the stage bits and performs a refresh. The status word reads {29'b0, ws1(bit2), ws0(bit1), enable(bit0)}.
- R5: A write to either offset word clears both stage bits and performs a refresh that uses the newly written offset.
- R6: While the enable bit is 0, a refresh leaves the compare value unchanged and no stage bit is set, whatever the count.
- R7: When enabled, with ws0 clear and count >= compare at a clock edge, ws0 becomes 1 and compare becomes count + offset. Both take effect on that edge.
- R8: When enabled, with ws0 set and count >= compare, ws1 becomes 1 and compare is left unchanged.
- R9: Writes to compare-low (control 0x010) and compare-high (control 0x014) replace that half of the compare value and leave the status bits unchanged. Such a write, or any refresh, takes priority over an expiry in the same cycle.
- R10: `irq_o` equals ws0 and `rst_req_o` equals ws1.
- R11: An access to an address that neither window decodes reads as zero and changes no state. Misaligned addresses are treated as undecoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 64 | Free-running system count |
| rf_sel_i | input | 1 | Refresh window access strobe |
| rf_we_i | input | 1 | Refresh window write (1) or read (0) |
| rf_addr_i | input | 12 | Refresh window byte address |
| rf_wdata_i | input | 32 | Refresh window write data |
| rf_rdata_o | output | 32 | Refresh window read data |
| cf_sel_i | input | 1 | Control window access strobe |
| cf_we_i | input | 1 | Control window write (1) or read (0) |
| cf_addr_i | input | 12 | Control window byte address |
| cf_wdata_i | input | 32 | Control window write data |
| cf_rdata_o | output | 32 | Control window read data |
| irq_o | output | 1 | First-stage timeout interrupt |
| rst_req_o | output | 1 | Second-stage reset request |

## Verification
The assertions assume that `count_i` is a stable value at each clock edge and that the write strobes are held for exactly one cycle per access. They also assume that a write to the refresh window and a compare write on the control window in the same cycle are resolved by the refresh. The bench drives every access at the falling edge for one cycle and changes the count only at those points. It places counts on or just beyond the compare value, so each expiry falls on a known edge. It also puts a compare write on the exact edge where an expiry would otherwise fire.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_REFRESH = 12'h000;
  localparam logic [ADDR_W-1:0] A_STATUS  = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFS_LO  = 12'h008;
  localparam logic [ADDR_W-1:0] A_OFS_HI  = 12'h00C;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 12'h010;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 12'h014;
  localparam logic [ADDR_W-1:0] A_IDENT   = 12'hFCC;

  localparam logic [31:0] ID_DEFAULT = 32'h0100_1A3B;

  // control window word index
  typedef enum int {
    CW_STATUS = 0, CW_OFS_LO = 1, CW_OFS_HI = 2,
    CW_CMP_LO = 3, CW_CMP_HI = 4, CW_IDENT = 5, CW_NUM = 6
  } cw_idx_e;

  // refresh window word index
  typedef enum int { RW_KICK = 0, RW_IDENT = 1, RW_NUM = 2 } rw_idx_e;

  typedef struct packed {
    logic ws1;
    logic ws0;
    logic en;
  } wdog_stat_t;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode #(
  parameter int AW = 12,
  parameter int N  = 2,
  parameter logic [N-1:0][AW-1:0] MAP = '0
) (
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  hit_o
);
  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit_o[g] = sel_i && aligned && (addr_i == MAP[g]);
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int OFS_W = 48,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             kick_we_i,
  input  logic             stat_we_i,
  input  logic             olo_we_i,
  input  logic             ohi_we_i,
  input  logic             clo_we_i,
  input  logic             chi_we_i,
  output wdog_stat_t       stat_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic [CNT_W-1:0] cmp_o
);
  localparam int OHI_W = OFS_W - DW;
  localparam int CHI_W = CNT_W - DW;

  wdog_stat_t       stat_q;
  logic [OFS_W-1:0] ofs_q, ofs_nxt;
  logic [CNT_W-1:0] cmp_q;
  logic             en_nxt, refresh, cmp_we, expire;
  logic [CNT_W-1:0] deadline_nxt, deadline_cur;

  always_comb begin
    ofs_nxt = ofs_q;
    if (olo_we_i) ofs_nxt[DW-1:0]     = wdata_i;
    if (ohi_we_i) ofs_nxt[OFS_W-1:DW] = wdata_i[OHI_W-1:0];
  end

  assign en_nxt       = stat_we_i ? wdata_i[0] : stat_q.en;
  assign refresh      = kick_we_i | stat_we_i | olo_we_i | ohi_we_i;
  assign cmp_we       = clo_we_i | chi_we_i;
  assign deadline_nxt = count_i + CNT_W'(ofs_nxt);
  assign deadline_cur = count_i + CNT_W'(ofs_q);
  // software action in the same cycle wins over a timeout
  assign expire       = stat_q.en && (count_i >= cmp_q) && !refresh && !cmp_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ofs_q  <= '0;
      cmp_q  <= '0;
    end else begin
      ofs_q     <= ofs_nxt;
      stat_q.en <= en_nxt;
      if (refresh) begin
        stat_q.ws0 <= 1'b0;
        stat_q.ws1 <= 1'b0;
        if (en_nxt) cmp_q <= deadline_nxt;
      end else if (cmp_we) begin
        if (clo_we_i) cmp_q[DW-1:0]    <= wdata_i;
        if (chi_we_i) cmp_q[CNT_W-1:DW] <= wdata_i[CHI_W-1:0];
      end else if (expire) begin
        if (!stat_q.ws0) begin
          stat_q.ws0 <= 1'b1;
          cmp_q      <= deadline_cur;
        end else begin
          stat_q.ws1 <= 1'b1;
        end
      end
    end
  end

  assign stat_o = stat_q;
  assign ofs_o  = ofs_q;
  assign cmp_o  = cmp_q;

  // R4: status write clears both stages
  a_r4_status_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> (!stat_q.ws0 && !stat_q.ws1));
  // R5: offset write clears both stages
  a_r5_offset_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (olo_we_i || ohi_we_i) |=> (!stat_q.ws0 && !stat_q.ws1));
  // R2: refresh-window kick clears both stages
  a_r2_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_we_i |=> (!stat_q.ws0 && !stat_q.ws1));
  // R6: disabled watchdog never escalates
  a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q.en |=> (!$rose(stat_q.ws0) && !$rose(stat_q.ws1)));
  // R8: second stage only follows the first
  a_r8_ws1_after_ws0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q.ws1) |-> $past(stat_q.ws0));
  // R9: direct compare write keeps status
  a_r9_cmp_write_keeps_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we && !refresh) |=> $stable(stat_q));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int          CNT_W    = 64,
  parameter int          OFS_W    = 48,
  parameter int          DW       = 32,
  parameter logic [31:0] ID_VALUE = ID_DEFAULT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rf_sel_i,
  input  logic             rf_we_i,
  input  logic [ADDR_W-1:0] rf_addr_i,
  input  logic [DW-1:0]    rf_wdata_i,
  output logic [DW-1:0]    rf_rdata_o,
  input  logic             cf_sel_i,
  input  logic             cf_we_i,
  input  logic [ADDR_W-1:0] cf_addr_i,
  input  logic [DW-1:0]    cf_wdata_i,
  output logic [DW-1:0]    cf_rdata_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam int OHI_W = OFS_W - DW;
  localparam int CHI_W = CNT_W - DW;
  localparam logic [CW_NUM-1:0][ADDR_W-1:0] CW_MAP =
    {A_IDENT, A_CMP_HI, A_CMP_LO, A_OFS_HI, A_OFS_LO, A_STATUS};
  localparam logic [RW_NUM-1:0][ADDR_W-1:0] RW_MAP = {A_IDENT, A_REFRESH};

  logic [CW_NUM-1:0] cw_hit;
  logic [RW_NUM-1:0] rw_hit;
  wdog_stat_t        stat;
  logic [OFS_W-1:0]  ofs;
  logic [CNT_W-1:0]  cmp;

  wdog_decode #(.AW(ADDR_W), .N(CW_NUM), .MAP(CW_MAP)) u_cw_dec (
    .sel_i(cf_sel_i), .addr_i(cf_addr_i), .hit_o(cw_hit));
  wdog_decode #(.AW(ADDR_W), .N(RW_NUM), .MAP(RW_MAP)) u_rw_dec (
    .sel_i(rf_sel_i), .addr_i(rf_addr_i), .hit_o(rw_hit));

  wdog_core #(.CNT_W(CNT_W), .OFS_W(OFS_W), .DW(DW)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count_i),
    .wdata_i   (cf_we_i && cf_sel_i ? cf_wdata_i : rf_wdata_i),
    .kick_we_i (rf_we_i && rw_hit[RW_KICK]),
    .stat_we_i (cf_we_i && cw_hit[CW_STATUS]),
    .olo_we_i  (cf_we_i && cw_hit[CW_OFS_LO]),
    .ohi_we_i  (cf_we_i && cw_hit[CW_OFS_HI]),
    .clo_we_i  (cf_we_i && cw_hit[CW_CMP_LO]),
    .chi_we_i  (cf_we_i && cw_hit[CW_CMP_HI]),
    .stat_o    (stat),
    .ofs_o     (ofs),
    .cmp_o     (cmp)
  );

  always_comb begin
    cf_rdata_o = '0;
    if (!cf_we_i) begin
      unique case (1'b1)
        cw_hit[CW_STATUS]: cf_rdata_o = DW'(stat);
        cw_hit[CW_OFS_LO]: cf_rdata_o = ofs[DW-1:0];
        cw_hit[CW_OFS_HI]: cf_rdata_o = DW'(ofs[OFS_W-1:DW]);
        cw_hit[CW_CMP_LO]: cf_rdata_o = cmp[DW-1:0];
        cw_hit[CW_CMP_HI]: cf_rdata_o = DW'(cmp[CNT_W-1:DW]);
        cw_hit[CW_IDENT]:  cf_rdata_o = DW'(ID_VALUE);
        default:           cf_rdata_o = '0;
      endcase
    end
  end

  assign rf_rdata_o = (!rf_we_i && rw_hit[RW_IDENT]) ? DW'(ID_VALUE) : '0;
  assign irq_o      = stat.ws0;
  assign rst_req_o  = stat.ws1;

  // R2: refresh word reads as zero
  a_r2_kick_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_sel_i && !rf_we_i && rf_addr_i == A_REFRESH) |-> (rf_rdata_o == '0));
  // R11: undecoded control-window write leaves the outputs alone
  a_r11_undecoded_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_sel_i && cf_we_i && cw_hit == '0 && !rf_sel_i && !stat.en)
      |=> ($stable(irq_o) && $stable(rst_req_o)));
  // R10: reset request is never raised without the interrupt stage before it
  a_r10_req_follows_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(irq_o));
endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  import wdog_pkg::*;

  localparam logic [31:0] IDV = ID_DEFAULT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        rf_sel = 0, rf_we = 0, cf_sel = 0, cf_we = 0;
  logic [11:0] rf_addr = '0, cf_addr = '0;
  logic [31:0] rf_wdata = '0, cf_wdata = '0;
  logic [31:0] rf_rdata, cf_rdata;
  logic        irq, rst_req;

  always #10 clk = ~clk;  // 50 MHz

  wdog_two_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt),
    .rf_sel_i(rf_sel), .rf_we_i(rf_we), .rf_addr_i(rf_addr),
    .rf_wdata_i(rf_wdata), .rf_rdata_o(rf_rdata),
    .cf_sel_i(cf_sel), .cf_we_i(cf_we), .cf_addr_i(cf_addr),
    .cf_wdata_i(cf_wdata), .cf_rdata_o(cf_rdata),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  // scoreboard: kind 0 = refresh rdata, 1 = control rdata, 2 = pins {rst_req, irq}
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        mon_ev;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        automatic int          k = kind_q.pop_front();
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        automatic logic [31:0] a;
        a = (k == 0) ? rf_rdata : (k == 1) ? cf_rdata : {30'b0, rst_req, irq};
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, a, e);
        end
      end
    end
  end

  task automatic push(input int k, input logic [31:0] e, input string t);
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
    #2 ->mon_ev;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic cf_wr(input logic [11:0] a, input logic [31:0] d);
    cf_sel = 1; cf_we = 1; cf_addr = a; cf_wdata = d;
    @(negedge clk);
    cf_sel = 0; cf_we = 0;
  endtask

  task automatic rf_wr(input logic [11:0] a, input logic [31:0] d);
    rf_sel = 1; rf_we = 1; rf_addr = a; rf_wdata = d;
    @(negedge clk);
    rf_sel = 0; rf_we = 0;
  endtask

  task automatic cf_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    cf_sel = 1; cf_we = 0; cf_addr = a;
    push(1, e, t);
    @(negedge clk);
    cf_sel = 0;
  endtask

  task automatic rf_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    rf_sel = 1; rf_we = 0; rf_addr = a;
    push(0, e, t);
    @(negedge clk);
    rf_sel = 0;
  endtask

  task automatic pins(input logic [1:0] e, input string t);
    push(2, {30'b0, e}, t);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      summary();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    idle();

    // R1 reset state
    cf_rd(A_STATUS, 32'h0, "R1 status");
    cf_rd(A_OFS_LO, 32'h0, "R1 ofs lo");
    cf_rd(A_OFS_HI, 32'h0, "R1 ofs hi");
    cf_rd(A_CMP_LO, 32'h0, "R1 cmp lo");
    cf_rd(A_CMP_HI, 32'h0, "R1 cmp hi");
    cf_rd(A_IDENT,  IDV,   "R1 ctrl ident");
    rf_rd(A_IDENT,  IDV,   "R1 refresh ident");
    pins(2'b00, "R1 pins");

    // R3 offset storage, R6 disabled refresh
    cf_wr(A_OFS_LO, 32'h0000_0010);
    cf_wr(A_OFS_HI, 32'hABCD_1234);
    cf_rd(A_OFS_HI, 32'h0000_1234, "R3 ofs hi masked");
    cf_rd(A_OFS_LO, 32'h0000_0010, "R3 ofs lo");
    cf_rd(A_CMP_LO, 32'h0, "R6 cmp untouched while disabled");
    cf_wr(A_OFS_HI, 32'h0);
    cnt = 64'd1000; idle();
    pins(2'b00, "R6 no expiry while disabled");
    cf_rd(A_STATUS, 32'h0, "R6 status while disabled");

    // R11 undecoded and misaligned
    cf_wr(12'h018, 32'hFFFF_FFFF);
    cf_wr(12'h009, 32'h0000_0055);
    cf_rd(12'h018, 32'h0, "R11 undecoded read");
    cf_rd(12'h009, 32'h0, "R11 misaligned read");
    cf_rd(A_OFS_LO, 32'h0000_0010, "R11 ofs lo unchanged");
    cf_rd(A_STATUS, 32'h0, "R11 status unchanged");

    // R4 enable via status write
    cnt = 64'd100;
    cf_wr(A_STATUS, 32'hFFFF_FFFF);
    cf_rd(A_STATUS, 32'h1, "R4 only enable kept");
    cf_rd(A_CMP_LO, 32'd116, "R4 refresh loads compare");
    cf_rd(A_CMP_HI, 32'h0, "R4 compare hi");

    // R7 first expiry
    cnt = 64'd116; idle();
    cf_rd(A_STATUS, 32'h3, "R7 ws0 set");
    pins(2'b01, "R7 R10 irq raised");
    cf_rd(A_CMP_LO, 32'd132, "R7 rearmed");

    // R8 second expiry
    cnt = 64'd132; idle();
    cf_rd(A_STATUS, 32'h7, "R8 ws1 set");
    pins(2'b11, "R8 R10 reset request");
    cf_rd(A_CMP_LO, 32'd132, "R8 compare unchanged");

    // R11 undecoded refresh-window write keeps status
    rf_wr(12'h008, 32'h1234_5678);
    cf_rd(A_STATUS, 32'h7, "R11 refresh window undecoded write");
    rf_rd(12'h008, 32'h0, "R11 refresh window undecoded read");

    // R2 refresh window
    rf_rd(A_REFRESH, 32'h0, "R2 kick reads zero");
    cf_rd(A_STATUS, 32'h7, "R2 kick read no effect");
    cnt = 64'd200;
    rf_wr(A_REFRESH, 32'hDEAD_BEEF);
    cf_rd(A_STATUS, 32'h1, "R2 kick clears stages");
    pins(2'b00, "R2 R10 pins cleared");
    cf_rd(A_CMP_LO, 32'd216, "R2 kick reloads compare");

    // R9 direct compare writes
    cf_wr(A_CMP_LO, 32'd250);
    cf_rd(A_CMP_LO, 32'd250, "R9 cmp lo written");
    cf_rd(A_STATUS, 32'h1, "R9 status kept");
    cnt = 64'd250; idle();
    cf_rd(A_STATUS, 32'h3, "R9 R7 expiry on written compare");
    cf_wr(A_CMP_HI, 32'd5);
    cf_rd(A_CMP_HI, 32'd5, "R9 cmp hi written");
    cf_rd(A_STATUS, 32'h3, "R9 status kept after cmp hi");
    pins(2'b01, "R9 irq kept");

    // R5 offset write refreshes with new offset
    cnt = 64'd300;
    cf_wr(A_OFS_LO, 32'h20);
    cf_rd(A_STATUS, 32'h1, "R5 offset write clears stages");
    pins(2'b00, "R5 irq dropped");
    cf_rd(A_CMP_LO, 32'd332, "R5 new offset used");
    cf_rd(A_CMP_HI, 32'h0, "R5 cmp hi reloaded");

    // R9 compare write beats a same-cycle expiry
    cnt = 64'd400;
    cf_wr(A_CMP_LO, 32'd1000);
    cf_rd(A_STATUS, 32'h1, "R9 write wins over expiry");
    cf_rd(A_CMP_LO, 32'd1000, "R9 priority compare value");
    pins(2'b00, "R9 no irq");

    // R6 disable
    cnt = 64'd2000;
    cf_wr(A_STATUS, 32'h0);
    cf_rd(A_STATUS, 32'h0, "R6 disabled");
    cf_rd(A_CMP_LO, 32'd1000, "R6 compare unchanged on disable");
    idle();
    pins(2'b00, "R6 no expiry past compare");

    done = 1;
    summary();
  end
endmodule